// File: doc/BRIEF.md
# Lockable Security Configuration Register

This block holds the security settings of a chip in one bus-visible word. The settings are the key-source select, a three-copy engine enable, an upset-monitor arm, a secure-boot status flag and a secure non-invasive debug enable. A second word holds five lock bits, one for each setting. Once a lock bit is set, its setting can no longer change until the next power-on reset.

The block also raises a sticky lockdown flag in two cases. The first is when the three engine-enable copies disagree. The second is when an external upset pulse arrives while the monitor is armed. Software writes the settings through a simple write-strobe port, and reads them back combinationally. Boot-side logic sets the secure-boot flag through a dedicated input. The power-on reset is the only thing that clears any setting, lock bit or the lockdown flag.

Top module: `seccfg_lockreg`

## Requirements
- R1: After power-on reset the configuration word reads 0x0000_2000, the lock word reads 0, and key_sel_fuse, engine_en, secure_boot, debug_en and lockdown are all 0.
- R2: A write to the configuration word (address CFG_ADDR, default 0) updates these fields. Bit 12 is the key source (0 = battery-backed key store, 1 = fuse key). Bits 11:9 are the engine enable. Bit 6 is the debug enable. Each field reads back at the same position. engine_en is 1 only while bits 11:9 hold 111.
- R3: The lock word (address LOCK_ADDR, default 4) has five bits. Bit 4 guards the key source, bit 3 the engine enable, bit 2 the upset arm, bit 1 the secure-boot flag and bit 0 the debug enable. Writing a 1 sets a lock bit, writing a 0 leaves it unchanged, and the lock bits read back at bits 4:0.
- R4: A write to a locked field is ignored. Unlocked fields carried in the same write still update.
- R5: A stored engine code other than 000 or 111 sets lockdown on the clock edge after the edge that stored it.
- R6: Bit 8 (upset arm) is set by writing 1. Writing 0 does not clear it, and it reads back at bit 8.
- R7: While the upset arm is 1, an upset_in high at a clock edge sets lockdown at that edge. While the arm is 0, upset_in has no effect.
- R8: Bit 7 (secure-boot flag) ignores bus writes. It is set by a boot_sec_set pulse unless lock bit 1 is set, and it stays set.
- R9: Bit 13 always reads 1, whatever value is written to it.
- R10: Once lockdown is 1 it stays 1. Rewriting a valid engine code does not clear it.
- R11: A write to any address other than the two words changes nothing, and a read of such an address returns 0.
- R12: Asserting por_n low returns every field, lock bit and lockdown to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, the only reset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| boot_sec_set | input | 1 | Boot-side request to set the secure-boot flag |
| upset_in | input | 1 | External upset indication, synchronous to clk |
| key_sel_fuse | output | 1 | Key source select, 1 = fuse key |
| engine_en | output | 1 | Engine enabled (stored code 111) |
| secure_boot | output | 1 | Secure-boot status flag |
| debug_en | output | 1 | Secure non-invasive debug enable |
| lockdown | output | 1 | Sticky secure lockdown flag |

## Verification
The assertions check four rules on every cycle:
- a locked field holds its value;
- sticky fields and lock bits never fall;
- lockdown follows an invalid engine code or an armed upset within one edge, and never clears;
- lockdown stays low when neither cause is present.

Only the bench scenarios can show the other behaviours:
- the exact bit positions seen on the read port, and the constant reserved bit;
- the mixed write where locked and unlocked fields share one word;
- the zero returned from unmapped addresses;
- the complete return to the reset state when power-on reset is applied a second time.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;
   // Field positions in the configuration word; decoded by software.
   localparam int unsigned POS_DBG   = 6;
   localparam int unsigned POS_SBOOT = 7;
   localparam int unsigned POS_ARM   = 8;
   localparam int unsigned POS_ENG   = 9;
   localparam int unsigned ENG_W     = 3;
   localparam int unsigned POS_KEY   = 12;
   localparam int unsigned POS_RSVD  = 13;
   localparam int unsigned CFG_MSB   = POS_RSVD;

   // Lock bit indices in the lock word.
   localparam int unsigned LK_DBG   = 0;
   localparam int unsigned LK_SBOOT = 1;
   localparam int unsigned LK_ARM   = 2;
   localparam int unsigned LK_ENG   = 3;
   localparam int unsigned LK_KEY   = 4;
   localparam int unsigned LOCK_N   = 5;

   typedef struct packed {
      logic             key;
      logic [ENG_W-1:0] eng;
      logic             arm;
      logic             sboot;
      logic             dbg;
   } seccfg_fields_t;
endpackage

// File: rtl/seccfg_field.sv
module seccfg_field #(
   parameter int unsigned W      = 1,
   parameter bit          STICKY = 1'b0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wr_en,
   input  logic         lock,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_chk_w
      $error("seccfg_field: W must be at least 1");
   end

   if (STICKY) begin : g_sticky
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)               q <= '0;
         else if (wr_en && !lock)  q <= q | d;
      end

      a_r6_sticky_never_falls: assert property (@(posedge clk) disable iff (!por_n)
         (($past(q) & ~q) == '0));
   end else begin : g_plain
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)               q <= '0;
         else if (wr_en && !lock)  q <= d;
      end
   end

   // R4: a lock seen at an edge means that edge leaves the field untouched
   a_r4_locked_field_holds: assert property (@(posedge clk) disable iff (!por_n)
      lock |=> $stable(q));
endmodule

// File: rtl/seccfg_lock_bank.sv
module seccfg_lock_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wr_en,
   input  logic [N-1:0] d,
   output logic [N-1:0] lock_q
);
   if (N < 1) begin : g_chk_n
      $error("seccfg_lock_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)               lock_q[i] <= 1'b0;
         else if (wr_en && d[i])   lock_q[i] <= 1'b1;
      end
   end

   a_r3_lock_bits_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (($past(lock_q) & ~lock_q) == '0));

   a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && (d == '0)) |=> $stable(lock_q));
endmodule

// File: rtl/seccfg_lockdown.sv
module seccfg_lockdown #(
   parameter int unsigned ENG_W = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [ENG_W-1:0] eng_q,
   input  logic             arm_q,
   input  logic             upset_in,
   output logic             lockdown
);
   localparam logic [ENG_W-1:0] CODE_OFF = '0;
   localparam logic [ENG_W-1:0] CODE_ON  = '1;

   if (ENG_W < 2) begin : g_chk_w
      $error("seccfg_lockdown: redundancy needs ENG_W >= 2");
   end

   logic code_bad;
   logic upset_hit;

   assign code_bad  = (eng_q != CODE_OFF) && (eng_q != CODE_ON);
   assign upset_hit = arm_q && upset_in;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                      lockdown <= 1'b0;
      else if (code_bad || upset_hit)  lockdown <= 1'b1;
   end

   a_r5_bad_code_trips: assert property (@(posedge clk) disable iff (!por_n)
      ((eng_q != CODE_OFF) && (eng_q != CODE_ON)) |=> lockdown);

   a_r7_armed_upset_trips: assert property (@(posedge clk) disable iff (!por_n)
      (arm_q && upset_in) |=> lockdown);

   a_r7_quiet_without_cause: assert property (@(posedge clk) disable iff (!por_n)
      (!lockdown && !(arm_q && upset_in) && ((eng_q == CODE_OFF) || (eng_q == CODE_ON)))
      |=> !lockdown);

   a_r10_lockdown_sticky: assert property (@(posedge clk) disable iff (!por_n)
      !$fell(lockdown));
endmodule

// File: rtl/seccfg_lockreg.sv
module seccfg_lockreg
   import seccfg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CFG_ADDR  = 0,
   parameter int unsigned LOCK_ADDR = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              boot_sec_set,
   input  logic              upset_in,
   output logic              key_sel_fuse,
   output logic              engine_en,
   output logic              secure_boot,
   output logic              debug_en,
   output logic              lockdown
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
   localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_ADDR);

   if (DATA_W <= CFG_MSB) begin : g_chk_data
      $error("seccfg_lockreg: DATA_W too narrow for the field map");
   end
   if (CFG_ADDR == LOCK_ADDR) begin : g_chk_alias
      $error("seccfg_lockreg: word addresses must differ");
   end
   if ((CFG_ADDR >> ADDR_W) != 0 || (LOCK_ADDR >> ADDR_W) != 0) begin : g_chk_range
      $error("seccfg_lockreg: address does not fit ADDR_W");
   end

   logic wr_cfg, wr_lock;
   logic [LOCK_N-1:0] lock_q;
   seccfg_fields_t    f;

   assign wr_cfg  = bus_we && (bus_addr == A_CFG);
   assign wr_lock = bus_we && (bus_addr == A_LOCK);

   seccfg_lock_bank #(.N(LOCK_N)) u_locks (
      .clk(clk), .por_n(por_n), .wr_en(wr_lock),
      .d(bus_wdata[LOCK_N-1:0]), .lock_q(lock_q)
   );

   seccfg_field #(.W(1), .STICKY(1'b0)) u_key (
      .clk(clk), .por_n(por_n), .wr_en(wr_cfg), .lock(lock_q[LK_KEY]),
      .d(bus_wdata[POS_KEY]), .q(f.key)
   );

   seccfg_field #(.W(ENG_W), .STICKY(1'b0)) u_eng (
      .clk(clk), .por_n(por_n), .wr_en(wr_cfg), .lock(lock_q[LK_ENG]),
      .d(bus_wdata[POS_ENG +: ENG_W]), .q(f.eng)
   );

   seccfg_field #(.W(1), .STICKY(1'b1)) u_arm (
      .clk(clk), .por_n(por_n), .wr_en(wr_cfg), .lock(lock_q[LK_ARM]),
      .d(bus_wdata[POS_ARM]), .q(f.arm)
   );

   seccfg_field #(.W(1), .STICKY(1'b1)) u_sboot (
      .clk(clk), .por_n(por_n), .wr_en(boot_sec_set), .lock(lock_q[LK_SBOOT]),
      .d(1'b1), .q(f.sboot)
   );

   seccfg_field #(.W(1), .STICKY(1'b0)) u_dbg (
      .clk(clk), .por_n(por_n), .wr_en(wr_cfg), .lock(lock_q[LK_DBG]),
      .d(bus_wdata[POS_DBG]), .q(f.dbg)
   );

   seccfg_lockdown #(.ENG_W(ENG_W)) u_ld (
      .clk(clk), .por_n(por_n), .eng_q(f.eng), .arm_q(f.arm),
      .upset_in(upset_in), .lockdown(lockdown)
   );

   // Assemble the configuration word from the stored fields.
   logic [DATA_W-1:0] cfg_word;
   always_comb begin
      cfg_word                   = '0;
      cfg_word[POS_RSVD]         = 1'b1;
      cfg_word[POS_KEY]          = f.key;
      cfg_word[POS_ENG +: ENG_W] = f.eng;
      cfg_word[POS_ARM]          = f.arm;
      cfg_word[POS_SBOOT]        = f.sboot;
      cfg_word[POS_DBG]          = f.dbg;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CFG)       bus_rdata = cfg_word;
      else if (bus_addr == A_LOCK) bus_rdata[LOCK_N-1:0] = lock_q;
   end

   assign key_sel_fuse = f.key;
   assign engine_en    = (f.eng == '1);
   assign secure_boot  = f.sboot;
   assign debug_en     = f.dbg;

   wire unused_wbits = ^bus_wdata;

   // R8: the secure-boot flag does not move on a bus write alone
   a_r8_sboot_bus_immune: assert property (@(posedge clk) disable iff (!por_n)
      (!boot_sec_set) |=> $stable(secure_boot));
endmodule

// File: tb/seccfg_lockreg_tb_top.sv
`timescale 1ns/1ps
module seccfg_lockreg_tb_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        boot_sec_set = 1'b0;
   logic        upset_in = 1'b0;
   logic        key_sel_fuse, engine_en, secure_boot, debug_en, lockdown;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   seccfg_lockreg dut_i (
      .clk(clk), .por_n(por_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boot_sec_set(boot_sec_set),
      .upset_in(upset_in), .key_sel_fuse(key_sel_fuse), .engine_en(engine_en),
      .secure_boot(secure_boot), .debug_en(debug_en), .lockdown(lockdown)
   );

   localparam logic [3:0] CFG = 4'd0, LCK = 4'd4, OTHER = 4'd8;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic do_por();
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_por();
      rd(CFG, v); chk("R1", "cfg after por", v, 32'h2000);
      rd(LCK, v); chk("R1", "lock after por", v, 32'h0);
      chk("R1", "outputs after por",
          {27'd0, key_sel_fuse, engine_en, secure_boot, debug_en, lockdown}, 32'h0);
   endtask

   task automatic t_rw();
      logic [31:0] v;
      do_por();
      wr(CFG, 32'h0000_1E40);
      rd(CFG, v); chk("R2", "cfg readback", v, 32'h3E40);
      chk("R2", "key/eng/dbg outputs", {29'd0, key_sel_fuse, engine_en, debug_en}, 32'h7);
      wr(CFG, 32'h0);
      rd(CFG, v); chk("R2", "cfg cleared", v, 32'h2000);
      chk("R2", "engine_en off", {31'd0, engine_en}, 32'h0);
      @(negedge clk);
      chk("R5", "valid codes no lockdown", {31'd0, lockdown}, 32'h0);
   endtask

   task automatic t_locks();
      logic [31:0] v;
      do_por();
      wr(LCK, 32'h11);
      rd(LCK, v); chk("R3", "lock set key+dbg", v, 32'h11);
      wr(LCK, 32'h04);
      rd(LCK, v); chk("R3", "zeros keep locks", v, 32'h15);
      wr(CFG, 32'h0000_1F40);
      rd(CFG, v); chk("R4", "only engine updates", v, 32'h2E00);
      chk("R4", "key and dbg outputs frozen", {30'd0, key_sel_fuse, debug_en}, 32'h0);
   endtask

   task automatic t_engine_bad();
      do_por();
      wr(CFG, 32'h0000_0400);
      chk("R5", "lockdown not yet", {31'd0, lockdown}, 32'h0);
      chk("R2", "partial code not enabled", {31'd0, engine_en}, 32'h0);
      @(negedge clk);
      chk("R5", "lockdown after invalid code", {31'd0, lockdown}, 32'h1);
      wr(CFG, 32'h0000_0E00);
      @(negedge clk);
      chk("R10", "lockdown stays", {31'd0, lockdown}, 32'h1);
   endtask

   task automatic pulse_upset();
      @(negedge clk); upset_in = 1'b1;
      @(negedge clk); upset_in = 1'b0;
   endtask

   task automatic t_upset();
      logic [31:0] v;
      do_por();
      pulse_upset();
      @(negedge clk);
      chk("R7", "disarmed upset ignored", {31'd0, lockdown}, 32'h0);
      wr(CFG, 32'h0000_0100);
      rd(CFG, v); chk("R6", "arm reads back", v, 32'h2100);
      wr(CFG, 32'h0);
      rd(CFG, v); chk("R6", "arm sticky", v, 32'h2100);
      pulse_upset();
      chk("R7", "armed upset trips", {31'd0, lockdown}, 32'h1);
   endtask

   task automatic t_sboot();
      logic [31:0] v;
      do_por();
      wr(CFG, 32'h0000_0080);
      rd(CFG, v); chk("R8", "bus write ignored", v, 32'h2000);
      @(negedge clk); boot_sec_set = 1'b1;
      @(negedge clk); boot_sec_set = 1'b0;
      rd(CFG, v); chk("R8", "boot set", v, 32'h2080);
      chk("R8", "secure_boot out", {31'd0, secure_boot}, 32'h1);
      do_por();
      wr(LCK, 32'h02);
      @(negedge clk); boot_sec_set = 1'b1;
      @(negedge clk); boot_sec_set = 1'b0;
      chk("R8", "locked set ignored", {31'd0, secure_boot}, 32'h0);
   endtask

   task automatic t_rsvd_unmapped();
      logic [31:0] v;
      do_por();
      wr(CFG, 32'h0);
      rd(CFG, v); chk("R9", "reserved bit stays 1", v, 32'h2000);
      wr(OTHER, 32'hFFFF_FFFF);
      rd(CFG, v); chk("R11", "cfg untouched", v, 32'h2000);
      rd(LCK, v); chk("R11", "lock untouched", v, 32'h0);
      rd(OTHER, v); chk("R11", "unmapped reads zero", v, 32'h0);
   endtask

   task automatic t_por_again();
      logic [31:0] v;
      do_por();
      wr(CFG, 32'h0000_1F40);
      wr(LCK, 32'h1F);
      wr(CFG, 32'h0000_0200);
      @(negedge clk);
      do_por();
      rd(CFG, v); chk("R12", "cfg back to reset", v, 32'h2000);
      rd(LCK, v); chk("R12", "locks cleared", v, 32'h0);
      chk("R12", "lockdown cleared", {31'd0, lockdown}, 32'h0);
   endtask

   initial begin
      t_reset();
      t_rw();
      t_locks();
      t_engine_bad();
      t_upset();
      t_sboot();
      t_rsvd_unmapped();
      t_por_again();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule